// File: doc/BRIEF.md
# DRAM Bank Row Timing Guard

This block watches a single DRAM bank and tells a command scheduler, cycle by cycle, whether an activate (open a row) or a precharge (close a row) may be issued to that bank now. It enforces three minimum intervals, each counted in clock cycles:

- activate to precharge (row active time)
- precharge to activate (precharge time)
- activate to activate (row cycle time)

Two activate limits apply independently, and the later of the two wins. One limit is the programmed row-cycle minimum. The other is the actual precharge cycle plus the precharge time. A precharge issued later than it could have been therefore stretches the row cycle past its programmed value.

The scheduler pulses a strobe whenever it issues a command. The guard updates its view of the bank, raises an error pulse for any command it would not have allowed, and ignores that command. On every accepted activate it reports the measured activate-to-activate gap, so that performance monitors can see how much row-cycle time is lost to late precharges.

A mode input replaces the programmed row-cycle minimum with the sum of the row active time and the precharge time. The timing inputs are captured only while the bank is closed.

Top module: `bank_row_guard`

## Requirements
- R1: During reset and in the first cycle after it, the bank is closed. `can_act_o`=1, `can_pre_o`=0, `cmd_err_o`=0 and `act_gap_o`=0. All elapsed-time counters start out expired.
- R2: An activate accepted in cycle 0 opens the row from cycle 1. `can_pre_o` is 1 in cycle k only while the row is open and k >= the captured row active time. A precharge accepted in cycle k closes the row from cycle k+1.
- R3: With `trc_sum_i`=0, `can_act_o` is 0 in cycle k after an activate in cycle 0 whenever k < `t_rc_i`. The input accepts values well above row active time plus precharge time, for example 150 with 30 and 34.
- R4: After a precharge accepted in cycle p, `can_act_o` stays 0 until cycle p + precharge time. The effective gap is therefore the larger of the row-cycle minimum and p + precharge time; a precharge at 76 with precharge time 34 and row cycle 100 allows the next activate at 110.
- R5: With `trc_sum_i`=1, `t_rc_i` is ignored and the row-cycle minimum equals row active time plus precharge time.
- R6: On each accepted activate, `act_gap_o` takes, from the next cycle, the number of cycles since the previous accepted activate. It holds that value until the next accepted activate. The first activate after reset reports all ones.
- R7: The three timing inputs and `trc_sum_i` are captured on every cycle in which the bank is closed and are frozen while a row is open. Changes made while a row is open apply only after the next precharge.
- R8: An activate while `can_act_o`=0 or a precharge while `can_pre_o`=0 raises `cmd_err_o` for exactly the next cycle and leaves the open/closed state unchanged. Errors caused by an activate to an open row or a precharge to a closed row are included.
- R9: `act_i` and `pre_i` high in the same cycle raise `cmd_err_o` in the next cycle, and both commands are ignored.
- R10: Elapsed-time counters saturate at 2^CW-1 instead of wrapping. After a long idle period the bank stays permitted, and `act_gap_o` reports 2^CW-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Activate issued this cycle |
| pre_i | input | 1 | Precharge issued this cycle |
| t_ras_i | input | TW | Minimum cycles from activate to precharge |
| t_rp_i | input | TW | Minimum cycles from precharge to activate |
| t_rc_i | input | TW | Minimum cycles from activate to activate |
| trc_sum_i | input | 1 | 1: row-cycle minimum is row active time plus precharge time |
| can_act_o | output | 1 | An activate is permitted this cycle |
| can_pre_o | output | 1 | A precharge is permitted this cycle |
| row_open_o | output | 1 | A row is open in the bank |
| cmd_err_o | output | 1 | One-cycle pulse after an illegal or conflicting command |
| act_gap_o | output | CW | Cycles between the last two accepted activates |

## Verification
The bench builds the guard with its defaults: 8-bit timing fields and 10-bit counters.

The 8-bit fields make a row-cycle minimum of 150, which is far above row active time plus precharge time, a legal setting. The late-precharge case (active time 66, precharge at 76, precharge time 34) can then be tested against its exact 110-cycle gap.

The 10-bit counters saturate at 1023. An idle stretch of about a thousand cycles is enough to show that a saturated counter stays permitted and that the reported gap stays at all ones.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_ACT  = 2'b01,
    CMD_PRE  = 2'b10,
    CMD_BOTH = 2'b11
  } rg_cmd_e;
endpackage

// File: rtl/rg_age_counter.sv
// Saturating elapsed-cycle counter: restart loads 1, idle counts up to all ones.
module rg_age_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] age
);
  localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] AGE_ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)
      age <= AGE_MAX;
    else if (restart)
      age <= AGE_ONE;
    else if (age != AGE_MAX)
      age <= age + AGE_ONE;
  end
endmodule

// File: rtl/rg_cfg_hold.sv
// Captures timing fields while the bank is closed; derives the row-cycle limit.
module rg_cfg_hold #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [TW-1:0] t_ras_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rc_i,
  input  logic          trc_sum_i,
  output logic [TW-1:0] ras_q,
  output logic [TW-1:0] rp_q,
  output logic [TW:0]   rc_eff
);
  logic [TW-1:0] rc_q;
  logic          sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q <= '0;
      rp_q  <= '0;
      rc_q  <= '0;
      sum_q <= 1'b0;
    end else if (capture) begin
      ras_q <= t_ras_i;
      rp_q  <= t_rp_i;
      rc_q  <= t_rc_i;
      sum_q <= trc_sum_i;
    end
  end

  always_comb begin
    if (sum_q)
      rc_eff = {1'b0, ras_q} + {1'b0, rp_q};
    else
      rc_eff = {1'b0, rc_q};
  end
endmodule

// File: rtl/rg_permit.sv
// Permit decode from the registered bank state and the elapsed-cycle counters.
module rg_permit #(
  parameter int TW = 8,
  parameter int CW = 10
) (
  input  logic          open_q,
  input  logic [CW-1:0] act_age,
  input  logic [CW-1:0] pre_age,
  input  logic [TW-1:0] ras_q,
  input  logic [TW-1:0] rp_q,
  input  logic [TW:0]   rc_eff,
  output logic          can_act,
  output logic          can_pre
);
  logic rc_met, rp_met, ras_met;

  always_comb begin
    rc_met  = act_age >= CW'(rc_eff);
    rp_met  = pre_age >= CW'(rp_q);
    ras_met = act_age >= CW'(ras_q);
    can_act = !open_q && rc_met && rp_met;
    can_pre = open_q && ras_met;
  end
endmodule

// File: rtl/bank_row_guard.sv
module bank_row_guard #(
  parameter int TW = 8,
  parameter int CW = TW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic [TW-1:0] t_ras_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rc_i,
  input  logic          trc_sum_i,
  output logic          can_act_o,
  output logic          can_pre_o,
  output logic          row_open_o,
  output logic          cmd_err_o,
  output logic [CW-1:0] act_gap_o
);
  import rg_pkg::*;

  rg_cmd_e       cmd;
  logic          open_q;
  logic          err_q;
  logic [CW-1:0] gap_q;
  logic [CW-1:0] act_age, pre_age;
  logic [TW-1:0] held_tras, held_trp;
  logic [TW:0]   rc_eff;
  logic          can_act, can_pre;
  logic          take_act, take_pre, illegal;

  assign cmd = rg_cmd_e'({pre_i, act_i});

  rg_cfg_hold #(.TW(TW)) u_cfg (
    .clk(clk), .rst(rst), .capture(!open_q),
    .t_ras_i(t_ras_i), .t_rp_i(t_rp_i), .t_rc_i(t_rc_i), .trc_sum_i(trc_sum_i),
    .ras_q(held_tras), .rp_q(held_trp), .rc_eff(rc_eff)
  );

  rg_age_counter #(.CW(CW)) u_act_age (
    .clk(clk), .rst(rst), .restart(take_act), .age(act_age)
  );

  rg_age_counter #(.CW(CW)) u_pre_age (
    .clk(clk), .rst(rst), .restart(take_pre), .age(pre_age)
  );

  rg_permit #(.TW(TW), .CW(CW)) u_permit (
    .open_q(open_q), .act_age(act_age), .pre_age(pre_age),
    .ras_q(held_tras), .rp_q(held_trp), .rc_eff(rc_eff),
    .can_act(can_act), .can_pre(can_pre)
  );

  always_comb begin
    take_act = (cmd == CMD_ACT) && can_act;
    take_pre = (cmd == CMD_PRE) && can_pre;
    illegal  = (cmd == CMD_BOTH) ||
               ((cmd == CMD_ACT) && !can_act) ||
               ((cmd == CMD_PRE) && !can_pre);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
      gap_q  <= '0;
    end else begin
      err_q <= illegal;
      if (take_act) begin
        open_q <= 1'b1;
        gap_q  <= act_age;
      end else if (take_pre) begin
        open_q <= 1'b0;
      end
    end
  end

  assign can_act_o  = can_act;
  assign can_pre_o  = can_pre;
  assign row_open_o = open_q;
  assign cmd_err_o  = err_q;
  assign act_gap_o  = gap_q;
endmodule

// File: rtl/rg_guard_checker.sv
module rg_guard_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          act_i,
  input logic          pre_i,
  input logic          can_act_o,
  input logic          can_pre_o,
  input logic          row_open_o,
  input logic          cmd_err_o,
  input logic [TW-1:0] held_tras
);
  assert_pre_needs_open_R2: assert property (@(posedge clk) disable iff (rst)
    can_pre_o |-> row_open_o);

  assert_act_needs_closed_R3: assert property (@(posedge clk) disable iff (rst)
    can_act_o |-> !row_open_o);

  assert_pre_closes_R2: assert property (@(posedge clk) disable iff (rst)
    (pre_i && !act_i && can_pre_o) |=> !row_open_o);

  assert_act_opens_R6: assert property (@(posedge clk) disable iff (rst)
    (act_i && !pre_i && can_act_o) |=> row_open_o);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    row_open_o |=> $stable(held_tras));

  assert_bad_act_err_R8: assert property (@(posedge clk) disable iff (rst)
    (act_i && !can_act_o) |=> (cmd_err_o && row_open_o == $past(row_open_o)));

  assert_bad_pre_err_R8: assert property (@(posedge clk) disable iff (rst)
    (pre_i && !can_pre_o) |=> (cmd_err_o && row_open_o == $past(row_open_o)));

  assert_quiet_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (!act_i && !pre_i) |=> !cmd_err_o);

  assert_both_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (act_i && pre_i) |=> (cmd_err_o && row_open_o == $past(row_open_o)));
endmodule

bind bank_row_guard rg_guard_checker #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .act_i(act_i), .pre_i(pre_i),
  .can_act_o(can_act_o), .can_pre_o(can_pre_o), .row_open_o(row_open_o),
  .cmd_err_o(cmd_err_o), .held_tras(held_tras)
);

// File: tb/bank_row_guard_tb.sv
`timescale 1ns/1ps
module bank_row_guard_tb;
  localparam int TW = 8;
  localparam int CW = TW + 2;
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          act_i = 1'b0, pre_i = 1'b0;
  logic [TW-1:0] t_ras_i = '0, t_rp_i = '0, t_rc_i = '0;
  logic          trc_sum_i = 1'b0;
  logic          can_act_o, can_pre_o, row_open_o, cmd_err_o;
  logic [CW-1:0] act_gap_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bank_row_guard #(.TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .act_i(act_i), .pre_i(pre_i),
    .t_ras_i(t_ras_i), .t_rp_i(t_rp_i), .t_rc_i(t_rc_i), .trc_sum_i(trc_sum_i),
    .can_act_o(can_act_o), .can_pre_o(can_pre_o), .row_open_o(row_open_o),
    .cmd_err_o(cmd_err_o), .act_gap_o(act_gap_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_cfg(input int ras, input int rp, input int rc, input bit sum);
    t_ras_i   = TW'(ras);
    t_rp_i    = TW'(rp);
    t_rc_i    = TW'(rc);
    trc_sum_i = sum;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    act_i = 1'b0;
    pre_i = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic pulse_act();
    act_i = 1'b1;
    step(1);
    act_i = 1'b0;
  endtask

  task automatic pulse_pre();
    pre_i = 1'b1;
    step(1);
    pre_i = 1'b0;
  endtask

  task automatic t_reset_state();
    set_cfg(12, 5, 20, 1'b0);
    do_reset();
    check("R1 row_open after reset", row_open_o, 0);
    check("R1 can_act after reset", can_act_o, 1);
    check("R1 can_pre after reset", can_pre_o, 0);
    check("R1 cmd_err after reset", cmd_err_o, 0);
    check("R1 gap after reset", act_gap_o, 0);
  endtask

  task automatic t_ras_window();
    set_cfg(12, 5, 20, 1'b0);
    do_reset();
    pulse_act();
    check("R2 row opens", row_open_o, 1);
    check("R6 first gap saturates", act_gap_o, SAT);
    step(10);
    check("R2 can_pre at age 11", can_pre_o, 0);
    step(1);
    check("R2 can_pre at age 12", can_pre_o, 1);
    check("R3 can_act while open", can_act_o, 0);
    pulse_pre();
    check("R2 row closes", row_open_o, 0);
    check("R2 no error on legal pre", cmd_err_o, 0);
  endtask

  task automatic t_long_rc();
    set_cfg(30, 34, 150, 1'b0);
    do_reset();
    pulse_act();
    step(29);
    pulse_pre();
    step(118);
    check("R3 can_act at age 149", can_act_o, 0);
    step(1);
    check("R3 can_act at age 150", can_act_o, 1);
    pulse_act();
    check("R3 gap with long rc", act_gap_o, 150);
  endtask

  task automatic t_late_pre();
    set_cfg(66, 34, 100, 1'b0);
    do_reset();
    pulse_act();
    step(75);
    pulse_pre();
    step(32);
    check("R4 can_act at age 109", can_act_o, 0);
    step(1);
    check("R4 can_act at age 110", can_act_o, 1);
    pulse_act();
    check("R4 stretched gap", act_gap_o, 110);
  endtask

  task automatic t_sum_mode();
    set_cfg(30, 34, 150, 1'b1);
    do_reset();
    pulse_act();
    step(29);
    pulse_pre();
    step(32);
    check("R5 can_act at age 63", can_act_o, 0);
    step(1);
    check("R5 can_act at age 64", can_act_o, 1);
    pulse_act();
    check("R5 gap equals ras+rp", act_gap_o, 64);
  endtask

  task automatic t_cfg_freeze();
    set_cfg(10, 3, 5, 1'b0);
    do_reset();
    pulse_act();
    t_ras_i = TW'(40);
    step(8);
    check("R7 old ras at age 9", can_pre_o, 0);
    step(1);
    check("R7 old ras at age 10", can_pre_o, 1);
    pulse_pre();
    step(3);
    check("R7 act permitted after pre", can_act_o, 1);
    pulse_act();
    step(38);
    check("R7 new ras at age 39", can_pre_o, 0);
    step(1);
    check("R7 new ras at age 40", can_pre_o, 1);
  endtask

  task automatic t_illegal();
    set_cfg(4, 2, 10, 1'b0);
    do_reset();
    pulse_pre();
    check("R8 pre to closed bank err", cmd_err_o, 1);
    check("R8 bank stays closed", row_open_o, 0);
    step(1);
    check("R8 err is one cycle", cmd_err_o, 0);
    pulse_act();
    check("R8 legal act no err", cmd_err_o, 0);
    pulse_act();
    check("R8 act to open bank err", cmd_err_o, 1);
    check("R8 bank stays open", row_open_o, 1);
    pulse_pre();
    check("R8 early pre err", cmd_err_o, 1);
    check("R8 early pre ignored", row_open_o, 1);
    step(1);
    check("R2 pre permitted at age 4", can_pre_o, 1);
    pulse_pre();
    check("R8 legal pre no err", cmd_err_o, 0);
    pulse_act();
    check("R8 early act err", cmd_err_o, 1);
    check("R8 early act ignored", row_open_o, 0);
  endtask

  task automatic t_both();
    set_cfg(4, 2, 6, 1'b0);
    do_reset();
    act_i = 1'b1;
    pre_i = 1'b1;
    step(1);
    act_i = 1'b0;
    pre_i = 1'b0;
    check("R9 both while closed err", cmd_err_o, 1);
    check("R9 both while closed ignored", row_open_o, 0);
    check("R9 act still permitted", can_act_o, 1);
    pulse_act();
    step(4);
    act_i = 1'b1;
    pre_i = 1'b1;
    step(1);
    act_i = 1'b0;
    pre_i = 1'b0;
    check("R9 both while open err", cmd_err_o, 1);
    check("R9 both while open ignored", row_open_o, 1);
  endtask

  task automatic t_saturate();
    set_cfg(4, 2, 6, 1'b0);
    do_reset();
    step(1100);
    check("R10 permitted after idle", can_act_o, 1);
    pulse_act();
    check("R10 gap saturates first", act_gap_o, SAT);
    step(3);
    pulse_pre();
    step(1100);
    check("R10 permitted after long idle", can_act_o, 1);
    pulse_act();
    check("R10 gap saturates again", act_gap_o, SAT);
    check("R6 gap holds while open", act_gap_o, SAT);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_ras_window();
    t_long_rc();
    t_late_pre();
    t_sum_mode();
    t_cfg_freeze();
    t_illegal();
    t_both();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule